// File: doc/BRIEF.md
# ATA Device Task File Registers

This block is the device-side register file of a parallel ATA target. The host selects a register with two active-low chip selects and a three-bit offset, then strobes a read or a write for one clock. The data register moves all 16 bits. Every other register uses only bits 7:0; on reads, bits 15:8 return zero. Reads and writes at the same offset often reach different registers. The block assembles the status and error bytes from its own flags and from live inputs supplied by a command engine.

A command write that is accepted hands the code to the engine as a one-cycle pulse and raises BSY. The engine later reports completion, with or without an error, through `done_i`. Completion sets a pending interrupt, which drives `intrq_o` unless it is masked. While BSY is high, command-block writes are dropped and every command-block read returns status. A soft reset (a bit in the device-control register) or the host reset line holds the block busy and clears the command-block registers. The block stays busy until the engine signals that reset has finished. A device-select bit in the device/head register is compared against a strap input. When they differ, the block answers reads with zero but still records writes to the shared registers.

Top module: `ata_taskfile_regs`

## Requirements
- R1: Address decode applies only when exactly one chip select is low.
  - With the command select low (`cs_cmd_n`=0, `cs_ctl_n`=1), offsets 0 to 7 map as follows: 0 data; 1 error (read) or features (write); 2 sector count; 3 sector number; 4 cylinder low; 5 cylinder high; 6 device/head; 7 status (read) or command (write).
  - With the control select low (`cs_cmd_n`=1, `cs_ctl_n`=0), offset 6 reads alternate status and writes device control.
  - Every other offset or chip-select combination reads as 0, and writes to it are ignored.
- R2: Read data is registered. It appears on `rdata_o` in the cycle after the read strobe and holds until the next read. The data register reads back all 16 bits as written. The 8-bit registers keep only bits 7:0 of a write and read with bits 15:8 at zero.
- R3: The status byte is {BSY, `drdy_i`, DF, `dsc_i`, DRQ, 0, 0, ERR}, with BSY at bit 7. DRQ equals `drq_i` while BSY is 0 and reads as 0 while BSY is 1.
- R4: A completion with `done_err_i`=1 sets ERR and loads the error register. `err_flags_i` bits 5..0 are {ICRC, UNC, IDNF, ABRT, TK0NF, AMNF}. They are placed at error bits 7, 6, 4, 2, 1 and 0, and error bits 5 and 3 read 0. A completion without error leaves ERR=0 and the error register at 0.
- R5: A command write from the selected device while BSY=0 is accepted. In the next cycle BSY is 1, `cmd_valid_o` is high for exactly one cycle with `cmd_code_o` equal to the written byte, and ERR, DF and any pending interrupt are cleared.
- R6: While BSY=1:
  - every read at a decoded offset returns the status byte;
  - writes to command-block registers have no effect;
  - device-control writes still take effect.
- R7: `done_i` while BSY=1 and no reset is pending clears BSY and sets the pending interrupt in the next cycle. `done_i` while BSY=0 has no effect.
- R8: A status read (command select, offset 7) by the selected device clears the pending interrupt. An alternate-status read leaves it pending.
- R9: `intrq_o` is high only when an interrupt is pending, device-control bit 1 (interrupt disable) is 0, and the device is selected.
- R10: A pulse on `wfault_i` sets DF. DF stays set until the next accepted command or a reset.
- R11: A reset condition is either `host_reset_n` low or a device-control write with bit 2 set.
  - It sets BSY and clears data, features, count, sector, both cylinder registers, device/head, ERR, DF, the error register and any pending interrupt.
  - A host reset also clears device control.
  - BSY then stays 1 until `reset_done_i` pulses while `host_reset_n` is high and device-control bit 2 is 0.
- R12: The device is selected when device/head bit 4 equals `dev_strap_i`. When it is not selected:
  - all reads return 0, and a status read does not clear the pending interrupt;
  - command and data writes are dropped;
  - writes to features, count, sector, cylinder, device/head and device control still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset; returns to idle with BSY=0 |
| host_reset_n | input | 1 | Host reset line, active low; starts a reset sequence |
| cs_cmd_n | input | 1 | Command-block chip select, active low |
| cs_ctl_n | input | 1 | Control-block chip select, active low |
| addr_i | input | 3 | Register offset |
| rd_stb_i | input | 1 | One-cycle read strobe |
| wr_stb_i | input | 1 | One-cycle write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| dev_strap_i | input | 1 | Device number this target answers to |
| drdy_i | input | 1 | Ready flag shown in status bit 6 |
| dsc_i | input | 1 | Seek-complete flag shown in status bit 4 |
| drq_i | input | 1 | Data-request flag shown in status bit 3 |
| wfault_i | input | 1 | Write-fault event pulse |
| cmd_valid_o | output | 1 | One-cycle pulse for an accepted command |
| cmd_code_o | output | 8 | Code of the accepted command |
| done_i | input | 1 | Command completion pulse from the engine |
| done_err_i | input | 1 | Completion ended in error |
| err_flags_i | input | 6 | Error cause flags {ICRC, UNC, IDNF, ABRT, TK0NF, AMNF} |
| reset_done_i | input | 1 | Reset processing finished |
| intrq_o | output | 1 | Interrupt request to the host |

## Verification
A BSY flag stuck or released early shows up one read later. A busy read then returns a register value instead of status, or a write that should be dropped changes what a following read returns. A pending-interrupt flag that acknowledges on the wrong read shows up on `intrq_o` in the cycle after that read. A selection compare with the wrong polarity shows up as data returned where zero is expected, or as a command pulse that should not appear. A reset path that misses a register shows up only on a read after `reset_done_i`, so every cleared register is read back once the reset has been released.

// File: rtl/ata_tf_pkg.sv
`timescale 1ns/1ps
package ata_tf_pkg;

  localparam int unsigned REG_W   = 8;
  localparam int unsigned OFF_W   = 3;
  localparam int unsigned NBANK   = 6;   // features, count, sector, cyl lo, cyl hi, dev/head
  localparam int unsigned BIDX_W  = $clog2(NBANK);
  localparam int unsigned FLAG_W  = 6;

  // device-control bits the host relies on
  localparam int unsigned CTL_NIEN_BIT = 1;
  localparam int unsigned CTL_SRST_BIT = 2;
  // device/head bit that picks the device
  localparam int unsigned DH_DEV_BIT   = 4;

  typedef enum logic [3:0] {
    SEL_NONE    = 4'd0,
    SEL_DATA    = 4'd1,
    SEL_ERRFEAT = 4'd2,
    SEL_COUNT   = 4'd3,
    SEL_SECTOR  = 4'd4,
    SEL_CYLLO   = 4'd5,
    SEL_CYLHI   = 4'd6,
    SEL_DEVHEAD = 4'd7,
    SEL_STATCMD = 4'd8,
    SEL_ALTCTL  = 4'd9
  } tf_sel_e;

  typedef struct packed {
    logic icrc;
    logic unc;
    logic idnf;
    logic abrt;
    logic tk0nf;
    logic amnf;
  } err_flags_t;

  // Status byte: busy masks the data request bit.
  function automatic logic [REG_W-1:0] pack_status(input logic bsy, input logic drdy,
                                                   input logic df, input logic dsc,
                                                   input logic drq, input logic err);
    return {bsy, drdy, df, dsc, drq & ~bsy, 2'b00, err};
  endfunction

  // Error byte: bits 5 and 3 unused.
  function automatic logic [REG_W-1:0] pack_error(input err_flags_t f);
    return {f.icrc, f.unc, 1'b0, f.idnf, 1'b0, f.abrt, f.tk0nf, f.amnf};
  endfunction

  // Map chip selects and offset to a register slot.
  function automatic tf_sel_e decode_sel(input logic cmd_cs, input logic ctl_cs,
                                         input logic [OFF_W-1:0] off);
    tf_sel_e s;
    s = SEL_NONE;
    if (cmd_cs && !ctl_cs) begin
      case (off)
        3'd0:    s = SEL_DATA;
        3'd1:    s = SEL_ERRFEAT;
        3'd2:    s = SEL_COUNT;
        3'd3:    s = SEL_SECTOR;
        3'd4:    s = SEL_CYLLO;
        3'd5:    s = SEL_CYLHI;
        3'd6:    s = SEL_DEVHEAD;
        default: s = SEL_STATCMD;
      endcase
    end else if (ctl_cs && !cmd_cs && off == 3'd6) begin
      s = SEL_ALTCTL;
    end
    return s;
  endfunction

endpackage

// File: rtl/ata_tf_decode.sv
`timescale 1ns/1ps
module ata_tf_decode
  import ata_tf_pkg::*;
(
  input  logic              cs_cmd_n,
  input  logic              cs_ctl_n,
  input  logic [OFF_W-1:0]  addr_i,
  output tf_sel_e           sel_o,
  output logic              bank_hit_o,
  output logic [BIDX_W-1:0] bank_idx_o
);

  logic [3:0] sel_num;

  always_comb begin
    sel_o   = decode_sel(!cs_cmd_n, !cs_ctl_n, addr_i);
    sel_num = sel_o;
    bank_hit_o = (sel_num >= 4'(SEL_ERRFEAT)) && (sel_num <= 4'(SEL_DEVHEAD));
    bank_idx_o = bank_hit_o ? BIDX_W'(sel_num - 4'(SEL_ERRFEAT)) : '0;
  end

  // R1: both selects asserted together never reaches a register
  always_comb begin
    if (!cs_cmd_n && !cs_ctl_n)
      p_dual_cs_none_r1: assert (sel_o == SEL_NONE);
  end

endmodule

// File: rtl/ata_tf_shadow.sv
`timescale 1ns/1ps
module ata_tf_shadow
  import ata_tf_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr_blk_i,
  input  logic                         clr_ctl_i,
  input  logic                         data_wr_i,
  input  logic                         bank_wr_i,
  input  logic [BIDX_W-1:0]            bank_idx_i,
  input  logic                         ctl_wr_i,
  input  logic [DATA_W-1:0]            wdata_i,
  output logic [DATA_W-1:0]            data_o,
  output logic [NBANK-1:0][REG_W-1:0]  bank_o,
  output logic [REG_W-1:0]             devctl_o
);

  logic [DATA_W-1:0] data_q;
  logic [REG_W-1:0]  devctl_q;
  logic [REG_W-1:0]  bank_q [NBANK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         data_q <= '0;
    else if (clr_blk_i) data_q <= '0;
    else if (data_wr_i) data_q <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         devctl_q <= '0;
    else if (clr_ctl_i) devctl_q <= '0;
    else if (ctl_wr_i)  devctl_q <= wdata_i[REG_W-1:0];
  end

  for (genvar gi = 0; gi < NBANK; gi++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[gi] <= '0;
      else if (clr_blk_i)
        bank_q[gi] <= '0;
      else if (bank_wr_i && bank_idx_i == BIDX_W'(gi))
        bank_q[gi] <= wdata_i[REG_W-1:0];
    end
    assign bank_o[gi] = bank_q[gi];
  end

  assign data_o   = data_q;
  assign devctl_o = devctl_q;

endmodule

// File: rtl/ata_tf_state.sv
`timescale 1ns/1ps
module ata_tf_state
  import ata_tf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rst_i,
  input  logic              srst_set_i,
  input  logic              srst_level_i,
  input  logic              cmd_accept_i,
  input  logic              done_i,
  input  logic              done_err_i,
  input  logic [FLAG_W-1:0] err_flags_i,
  input  logic              wfault_i,
  input  logic              reset_done_i,
  input  logic              status_ack_i,
  output logic              bsy_o,
  output logic              df_o,
  output logic              err_o,
  output logic [REG_W-1:0]  err_reg_o,
  output logic              irq_pend_o,
  output logic              rst_pend_o
);

  logic             bsy_q, df_q, err_q, irq_q, rst_pend_q;
  logic [REG_W-1:0] err_reg_q;
  logic             rst_evt_w;
  logic             done_fire_w;
  logic             rst_release_w;

  assign rst_evt_w     = host_rst_i | srst_set_i;
  assign done_fire_w   = done_i & bsy_q & ~rst_pend_q;
  assign rst_release_w = rst_pend_q & reset_done_i & ~srst_level_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy_q      <= 1'b0;
      df_q       <= 1'b0;
      err_q      <= 1'b0;
      irq_q      <= 1'b0;
      rst_pend_q <= 1'b0;
      err_reg_q  <= '0;
    end else if (rst_evt_w) begin
      bsy_q      <= 1'b1;
      df_q       <= 1'b0;
      err_q      <= 1'b0;
      irq_q      <= 1'b0;
      rst_pend_q <= 1'b1;
      err_reg_q  <= '0;
    end else if (rst_pend_q) begin
      if (rst_release_w) begin
        rst_pend_q <= 1'b0;
        bsy_q      <= 1'b0;
      end
    end else if (cmd_accept_i) begin
      bsy_q <= 1'b1;
      err_q <= 1'b0;
      irq_q <= 1'b0;
      df_q  <= wfault_i;
    end else begin
      if (done_fire_w) begin
        bsy_q     <= 1'b0;
        err_q     <= done_err_i;
        err_reg_q <= done_err_i ? pack_error(err_flags_t'(err_flags_i)) : '0;
        irq_q     <= 1'b1;
      end else if (status_ack_i) begin
        irq_q <= 1'b0;
      end
      if (wfault_i) df_q <= 1'b1;
    end
  end

  assign bsy_o      = bsy_q;
  assign df_o       = df_q;
  assign err_o      = err_q;
  assign err_reg_o  = err_reg_q;
  assign irq_pend_o = irq_q;
  assign rst_pend_o = rst_pend_q;

  // R5: an accepted command leaves the block busy
  p_cmd_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept_i && !rst_evt_w |=> bsy_q);

  // R7: completion frees the block and raises the interrupt
  p_done_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire_w && !rst_evt_w |=> !bsy_q && irq_q);

  // R7: completion while idle changes nothing
  p_idle_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_i && !bsy_q && !rst_evt_w && !cmd_accept_i |=> !bsy_q);

  // R8: a status read drops the pending interrupt
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status_ack_i && !done_fire_w && !rst_evt_w |=> !irq_q);

  // R10: a latched fault persists until a command or reset
  p_df_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    df_q && !cmd_accept_i && !rst_evt_w |=> df_q);

  // R11: a pending reset always reads busy
  p_reset_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend_q |-> bsy_q);

endmodule

// File: rtl/ata_taskfile_regs.sv
`timescale 1ns/1ps
module ata_taskfile_regs
  import ata_tf_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_reset_n,
  input  logic              cs_cmd_n,
  input  logic              cs_ctl_n,
  input  logic [2:0]        addr_i,
  input  logic              rd_stb_i,
  input  logic              wr_stb_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              dev_strap_i,
  input  logic              drdy_i,
  input  logic              dsc_i,
  input  logic              drq_i,
  input  logic              wfault_i,
  output logic              cmd_valid_o,
  output logic [7:0]        cmd_code_o,
  input  logic              done_i,
  input  logic              done_err_i,
  input  logic [5:0]        err_flags_i,
  input  logic              reset_done_i,
  output logic              intrq_o
);

  localparam int unsigned PAD_W     = DATA_W - REG_W;
  localparam int unsigned COUNT_IDX = 32'(SEL_COUNT) - 32'(SEL_ERRFEAT);

  // decode
  tf_sel_e             sel_w;
  logic                bank_hit_w;
  logic [BIDX_W-1:0]   bank_idx_w;

  // shadow contents
  logic [DATA_W-1:0]           data_w;
  logic [NBANK-1:0][REG_W-1:0] bank_w;
  logic [REG_W-1:0]            devctl_w;

  // state flags
  logic             bsy_w, df_w, err_w, irq_pend_w, rst_pend_w;
  logic [REG_W-1:0] err_reg_w;

  // named events
  logic             dev_match_w;
  logic             wr_go_w;
  logic             cmd_accept_w;
  logic             data_wr_w;
  logic             bank_wr_w;
  logic             ctl_wr_w;
  logic             srst_set_w;
  logic             host_rst_w;
  logic             clr_blk_w;
  logic             status_ack_w;
  logic [REG_W-1:0] status_w;
  logic [DATA_W-1:0] rd_val_w;

  logic [DATA_W-1:0] rdata_q;
  logic              cmd_valid_q;
  logic [7:0]        cmd_code_q;

  ata_tf_decode u_decode (
    .cs_cmd_n   (cs_cmd_n),
    .cs_ctl_n   (cs_ctl_n),
    .addr_i     (addr_i),
    .sel_o      (sel_w),
    .bank_hit_o (bank_hit_w),
    .bank_idx_o (bank_idx_w)
  );

  assign dev_match_w  = (bank_w[NBANK-1][DH_DEV_BIT] == dev_strap_i);
  assign host_rst_w   = ~host_reset_n;
  assign wr_go_w      = wr_stb_i && (sel_w != SEL_NONE) && (sel_w == SEL_ALTCTL || !bsy_w);
  assign cmd_accept_w = wr_go_w && (sel_w == SEL_STATCMD) && dev_match_w;
  assign data_wr_w    = wr_go_w && (sel_w == SEL_DATA) && dev_match_w;
  assign bank_wr_w    = wr_go_w && bank_hit_w;
  assign ctl_wr_w     = wr_go_w && (sel_w == SEL_ALTCTL);
  assign srst_set_w   = ctl_wr_w && wdata_i[CTL_SRST_BIT];
  assign clr_blk_w    = host_rst_w | srst_set_w;
  assign status_ack_w = rd_stb_i && (sel_w == SEL_STATCMD) && dev_match_w;

  ata_tf_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_blk_i  (clr_blk_w),
    .clr_ctl_i  (host_rst_w),
    .data_wr_i  (data_wr_w),
    .bank_wr_i  (bank_wr_w),
    .bank_idx_i (bank_idx_w),
    .ctl_wr_i   (ctl_wr_w),
    .wdata_i    (wdata_i),
    .data_o     (data_w),
    .bank_o     (bank_w),
    .devctl_o   (devctl_w)
  );

  ata_tf_state u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_rst_i   (host_rst_w),
    .srst_set_i   (srst_set_w),
    .srst_level_i (devctl_w[CTL_SRST_BIT]),
    .cmd_accept_i (cmd_accept_w),
    .done_i       (done_i),
    .done_err_i   (done_err_i),
    .err_flags_i  (err_flags_i),
    .wfault_i     (wfault_i),
    .reset_done_i (reset_done_i),
    .status_ack_i (status_ack_w),
    .bsy_o        (bsy_w),
    .df_o         (df_w),
    .err_o        (err_w),
    .err_reg_o    (err_reg_w),
    .irq_pend_o   (irq_pend_w),
    .rst_pend_o   (rst_pend_w)
  );

  assign status_w = pack_status(bsy_w, drdy_i, df_w, dsc_i, drq_i, err_w);

  // read mux: deselect and invalid first, then busy override
  always_comb begin
    rd_val_w = '0;
    if (sel_w == SEL_NONE || !dev_match_w) begin
      rd_val_w = '0;
    end else if (sel_w == SEL_ALTCTL || bsy_w) begin
      rd_val_w = {{PAD_W{1'b0}}, status_w};
    end else begin
      case (sel_w)
        SEL_DATA:    rd_val_w = data_w;
        SEL_ERRFEAT: rd_val_w = {{PAD_W{1'b0}}, err_reg_w};
        SEL_STATCMD: rd_val_w = {{PAD_W{1'b0}}, status_w};
        default:     rd_val_w = {{PAD_W{1'b0}}, bank_w[bank_idx_w]};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q     <= '0;
      cmd_valid_q <= 1'b0;
      cmd_code_q  <= '0;
    end else begin
      if (rd_stb_i) rdata_q <= rd_val_w;
      cmd_valid_q <= cmd_accept_w;
      if (cmd_accept_w) cmd_code_q <= wdata_i[7:0];
    end
  end

  assign rdata_o     = rdata_q;
  assign cmd_valid_o = cmd_valid_q;
  assign cmd_code_o  = cmd_code_q;
  assign intrq_o     = irq_pend_w & ~devctl_w[CTL_NIEN_BIT] & dev_match_w;

  // R5: the command pulse lasts one cycle
  p_cmd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);

  // R6: a busy read returns status, so bit 7 reads set
  p_busy_read_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i && bsy_w && dev_match_w && sel_w != SEL_NONE |=> rdata_o[REG_W-1]);

  // R6: writes into the count register are dropped while busy
  p_busy_blocks_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_i && bsy_w && sel_w == SEL_COUNT && host_reset_n |=> $stable(bank_w[COUNT_IDX]));

  // R11: no accepted command while a reset is outstanding
  p_no_cmd_in_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pend_w |=> !cmd_valid_o);

  // R12: the unselected device answers reads with zero
  p_desel_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb_i && !dev_match_w |=> rdata_o == '0);

endmodule

// File: tb/ata_taskfile_regs_tb.sv
`timescale 1ns/1ps
module ata_taskfile_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_reset_n = 1'b1;
  logic        cs_cmd_n = 1'b1;
  logic        cs_ctl_n = 1'b1;
  logic [2:0]  addr_i = '0;
  logic        rd_stb_i = 1'b0;
  logic        wr_stb_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        dev_strap_i = 1'b0;
  logic        drdy_i = 1'b1;
  logic        dsc_i = 1'b1;
  logic        drq_i = 1'b0;
  logic        wfault_i = 1'b0;
  logic        cmd_valid_o;
  logic [7:0]  cmd_code_o;
  logic        done_i = 1'b0;
  logic        done_err_i = 1'b0;
  logic [5:0]  err_flags_i = '0;
  logic        reset_done_i = 1'b0;
  logic        intrq_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  ata_taskfile_regs dut_i (
    .clk(clk), .rst_n(rst_n), .host_reset_n(host_reset_n),
    .cs_cmd_n(cs_cmd_n), .cs_ctl_n(cs_ctl_n), .addr_i(addr_i),
    .rd_stb_i(rd_stb_i), .wr_stb_i(wr_stb_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .dev_strap_i(dev_strap_i), .drdy_i(drdy_i), .dsc_i(dsc_i), .drq_i(drq_i),
    .wfault_i(wfault_i), .cmd_valid_o(cmd_valid_o), .cmd_code_o(cmd_code_o),
    .done_i(done_i), .done_err_i(done_err_i), .err_flags_i(err_flags_i),
    .reset_done_i(reset_done_i), .intrq_o(intrq_o)
  );

  // chip-select codes used by the bench
  localparam logic [1:0] CS_CMD = 2'd0, CS_CTL = 2'd1, CS_BOTH = 2'd2, CS_NONE = 2'd3;

  typedef struct packed {
    logic       is_wr;
    logic [1:0] csc;
    logic [2:0] off;
    logic [15:0] val;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t VECS [NV] = '{
    '{1'b1, CS_CMD, 3'd1, 16'h0011, 4'd1},   // R1 features
    '{1'b1, CS_CMD, 3'd2, 16'h0022, 4'd1},
    '{1'b1, CS_CMD, 3'd3, 16'h0033, 4'd1},
    '{1'b1, CS_CMD, 3'd4, 16'h0044, 4'd1},
    '{1'b1, CS_CMD, 3'd5, 16'h0055, 4'd1},
    '{1'b1, CS_CMD, 3'd6, 16'h00A6, 4'd1},   // dev bit 0 keeps selection
    '{1'b1, CS_CMD, 3'd0, 16'hBEEF, 4'd2},   // R2 data
    '{1'b0, CS_CMD, 3'd0, 16'hBEEF, 4'd2},   // R2 full width
    '{1'b0, CS_CMD, 3'd1, 16'h0000, 4'd4},   // R4 error empty, features not visible
    '{1'b0, CS_CMD, 3'd2, 16'h0022, 4'd1},
    '{1'b0, CS_CMD, 3'd3, 16'h0033, 4'd1},
    '{1'b0, CS_CMD, 3'd4, 16'h0044, 4'd1},
    '{1'b0, CS_CMD, 3'd5, 16'h0055, 4'd1},
    '{1'b0, CS_CMD, 3'd6, 16'h00A6, 4'd1},
    '{1'b0, CS_CMD, 3'd7, 16'h0050, 4'd3},   // R3 idle status
    '{1'b0, CS_CTL, 3'd6, 16'h0050, 4'd1},   // R1 alternate status
    '{1'b0, CS_CTL, 3'd7, 16'h0000, 4'd1},   // R1 invalid
    '{1'b0, CS_CTL, 3'd0, 16'h0000, 4'd1},
    '{1'b0, CS_BOTH, 3'd2, 16'h0000, 4'd1},
    '{1'b0, CS_NONE, 3'd2, 16'h0000, 4'd1},
    '{1'b1, CS_CMD, 3'd2, 16'hFF5A, 4'd2},   // R2 upper byte dropped
    '{1'b0, CS_CMD, 3'd2, 16'h005A, 4'd2},
    '{1'b1, CS_CTL, 3'd7, 16'h0004, 4'd1},   // R1 invalid write, no reset
    '{1'b0, CS_CMD, 3'd7, 16'h0050, 4'd1},
    '{1'b1, CS_BOTH, 3'd3, 16'h0099, 4'd1},
    '{1'b0, CS_CMD, 3'd3, 16'h0033, 4'd1},
    '{1'b1, CS_NONE, 3'd3, 16'h0099, 4'd1},
    '{1'b0, CS_CMD, 3'd3, 16'h0033, 4'd1}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_cs(input logic [1:0] c);
    cs_cmd_n = !(c == CS_CMD || c == CS_BOTH);
    cs_ctl_n = !(c == CS_CTL || c == CS_BOTH);
  endtask

  task automatic do_write(input logic [1:0] c, input logic [2:0] off, input logic [15:0] v);
    @(negedge clk);
    set_cs(c); addr_i = off; wdata_i = v; wr_stb_i = 1'b1;
    @(negedge clk);
    wr_stb_i = 1'b0; set_cs(CS_NONE);
  endtask

  task automatic do_read(input logic [1:0] c, input logic [2:0] off, output logic [15:0] v);
    @(negedge clk);
    set_cs(c); addr_i = off; rd_stb_i = 1'b1;
    @(negedge clk);
    rd_stb_i = 1'b0; set_cs(CS_NONE);
    v = rdata_o;
  endtask

  task automatic pulse_done(input logic e, input logic [5:0] f);
    @(negedge clk);
    done_i = 1'b1; done_err_i = e; err_flags_i = f;
    @(negedge clk);
    done_i = 1'b0; done_err_i = 1'b0; err_flags_i = '0;
  endtask

  task automatic pulse_rdone();
    @(negedge clk); reset_done_i = 1'b1;
    @(negedge clk); reset_done_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [15:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R2 reset rdata", rdata_o, 16'h0000);
    check("R9 reset intrq", {15'd0, intrq_o}, 16'd0);
    check("R5 reset cmd_valid", {15'd0, cmd_valid_o}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_wr) do_write(VECS[i].csc, VECS[i].off, VECS[i].val);
      else begin
        do_read(VECS[i].csc, VECS[i].off, rv);
        total++;
        if (rv !== VECS[i].val) begin
          bad++;
          $display("FAIL R%0d vector %0d actual=%h expected=%h", VECS[i].req, i, rv, VECS[i].val);
        end
      end
    end

    // R5 command accept and pulse
    do_write(CS_CMD, 3'd7, 16'h0020);
    check("R5 cmd_valid", {15'd0, cmd_valid_o}, 16'd1);
    check("R5 cmd_code", {8'd0, cmd_code_o}, 16'h0020);
    @(negedge clk);
    check("R5 one-cycle pulse", {15'd0, cmd_valid_o}, 16'd0);
    // R6 busy read returns status
    do_read(CS_CMD, 3'd2, rv); check("R6 busy read", rv, 16'h00D0);
    drq_i = 1'b1;
    do_read(CS_CMD, 3'd7, rv); check("R3 drq masked by busy", rv, 16'h00D0);
    do_write(CS_CMD, 3'd2, 16'h0077);          // R6 dropped
    do_write(CS_CTL, 3'd6, 16'h0002);          // R6 control still written: nIEN
    pulse_done(1'b0, 6'd0);
    check("R9 masked intrq", {15'd0, intrq_o}, 16'd0);
    do_read(CS_CMD, 3'd2, rv); check("R6 busy write ignored", rv, 16'h005A);
    do_read(CS_CTL, 3'd6, rv); check("R3 drq shown", rv, 16'h0058);
    drq_i = 1'b0;
    do_write(CS_CTL, 3'd6, 16'h0000);
    check("R9 unmasked intrq", {15'd0, intrq_o}, 16'd1);
    do_read(CS_CTL, 3'd6, rv);
    check("R8 alt status no ack", {15'd0, intrq_o}, 16'd1);
    do_read(CS_CMD, 3'd7, rv); check("R7 status after done", rv, 16'h0050);
    check("R8 status ack", {15'd0, intrq_o}, 16'd0);

    // R4 error completion
    do_write(CS_CMD, 3'd7, 16'h0030);
    pulse_done(1'b1, 6'b101101);
    do_read(CS_CMD, 3'd1, rv); check("R4 error layout", rv, 16'h0095);
    do_read(CS_CMD, 3'd7, rv); check("R4 ERR bit", rv, 16'h0051);

    // R10 write fault
    @(negedge clk); wfault_i = 1'b1;
    @(negedge clk); wfault_i = 1'b0;
    do_read(CS_CMD, 3'd7, rv); check("R10 DF set", rv, 16'h0071);
    repeat (3) @(negedge clk);
    do_read(CS_CMD, 3'd7, rv); check("R10 DF held", rv, 16'h0071);
    do_write(CS_CMD, 3'd7, 16'h0040);
    do_read(CS_CMD, 3'd7, rv); check("R10 DF cleared by command", rv, 16'h00D0);
    pulse_done(1'b0, 6'd0);
    do_read(CS_CMD, 3'd1, rv); check("R4 clean error reg", rv, 16'h0000);
    do_read(CS_CMD, 3'd7, rv); check("R4 clean status", rv, 16'h0050);

    // R7 done while idle
    pulse_done(1'b0, 6'd0);
    check("R7 idle done no irq", {15'd0, intrq_o}, 16'd0);
    do_read(CS_CTL, 3'd6, rv); check("R7 idle done status", rv, 16'h0050);

    // R9 / R12 selection
    do_write(CS_CMD, 3'd7, 16'h0020);
    pulse_done(1'b0, 6'd0);
    check("R9 intrq pending", {15'd0, intrq_o}, 16'd1);
    do_write(CS_CMD, 3'd6, 16'h0010);
    check("R9 deselected intrq", {15'd0, intrq_o}, 16'd0);
    do_read(CS_CMD, 3'd3, rv); check("R12 deselected read", rv, 16'h0000);
    do_read(CS_CMD, 3'd7, rv); check("R12 deselected status", rv, 16'h0000);
    do_write(CS_CMD, 3'd3, 16'h0066);
    do_write(CS_CMD, 3'd7, 16'h00EC);
    check("R12 command dropped", {15'd0, cmd_valid_o}, 16'd0);
    do_write(CS_CMD, 3'd0, 16'h1234);
    do_write(CS_CMD, 3'd6, 16'h0000);
    check("R12 no ack while deselected", {15'd0, intrq_o}, 16'd1);
    do_read(CS_CMD, 3'd3, rv); check("R12 shadow write landed", rv, 16'h0066);
    do_read(CS_CMD, 3'd0, rv); check("R12 data write dropped", rv, 16'hBEEF);
    do_read(CS_CMD, 3'd7, rv); check("R12 no busy from dropped cmd", rv, 16'h0050);

    // R11 soft reset
    do_write(CS_CMD, 3'd7, 16'h0050);
    pulse_done(1'b1, 6'b000100);
    do_write(CS_CTL, 3'd6, 16'h0004);
    check("R11 irq cleared", {15'd0, intrq_o}, 16'd0);
    do_read(CS_CMD, 3'd3, rv); check("R11 busy in reset", rv, 16'h00D0);
    pulse_rdone();
    do_read(CS_CTL, 3'd6, rv); check("R11 held while srst", rv, 16'h00D0);
    do_write(CS_CTL, 3'd6, 16'h0000);
    pulse_rdone();
    do_read(CS_CMD, 3'd7, rv); check("R11 released", rv, 16'h0050);
    do_read(CS_CMD, 3'd3, rv); check("R11 sector cleared", rv, 16'h0000);
    do_read(CS_CMD, 3'd0, rv); check("R11 data cleared", rv, 16'h0000);
    do_read(CS_CMD, 3'd1, rv); check("R11 error cleared", rv, 16'h0000);

    // R11 host reset
    do_write(CS_CMD, 3'd2, 16'h0012);
    do_write(CS_CTL, 3'd6, 16'h0002);
    @(negedge clk); host_reset_n = 1'b0;
    repeat (2) @(negedge clk);
    host_reset_n = 1'b1;
    do_read(CS_CMD, 3'd7, rv); check("R11 host reset busy", rv, 16'h00D0);
    pulse_rdone();
    do_read(CS_CMD, 3'd2, rv); check("R11 count cleared", rv, 16'h0000);
    do_write(CS_CMD, 3'd7, 16'h0020);
    pulse_done(1'b0, 6'd0);
    check("R11 control cleared", {15'd0, intrq_o}, 16'd1);
    do_read(CS_CMD, 3'd7, rv);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule